// File: doc/BRIEF.md
# Fractional Rate Governor Symbol Pacer

This block sets, for each stream of a multi-stream link, how many payload symbols may be released in each transport packet. Over many packets the released count averages to a target M = x_int + y_frac/256 symbols per packet. M counts symbols summed over all active lanes, not per lane. Each stream has its own 32-bit governor word that holds both fields.

A shared packet-start strobe marks every packet boundary. At each boundary an enabled stream adds y_frac into a fractional accumulator. If the add carries out, the quota for the packet is x_int + 1; otherwise it is x_int. During the packet the stream releases one symbol in each cycle where its upstream has a symbol ready and quota remains. Once the quota is spent it signals stuffing instead. Computing the governor values and spreading symbols over lanes are done elsewhere.

Top module: `rgp_pacer`

## Requirements
- R1: While reset is asserted, every `sym_release` and `stuff` bit is 0.
- R2: In each stream's 32-bit governor word, y_frac is bits [7:0] and x_int is bits [16 +: INT_W] (bits [25:16] by default). Bits [15:8] and the bits above x_int have no effect on any quota.
- R3: When y_frac is 0, every packet of that stream has a quota of exactly x_int.
- R4: Count an enabled stream's packets from k = 0, starting at the first boundary after the stream is enabled. Packet k then has quota x_int + floor((k+1)·y/256) − floor(k·y/256). Over 256 packets the total is 256·x_int + y_frac.
- R5: A symbol is released only in a cycle where the stream is enabled, a packet is open, `sym_ready` is 1 and fewer symbols than the quota have been released in this packet.
- R6: `stuff` is 1 in every non-boundary cycle of an open packet after its quota is spent, whatever the value of `sym_ready`. It is never 1 together with `sym_release`.
- R7: In the cycle that carries `pkt_start`, and from enabling a stream up to its first boundary, that stream outputs neither release nor stuff.
- R8: The governor word is sampled only at a packet boundary. A change made inside a packet leaves that packet's quota unchanged and applies from the next packet.
- R9: While a stream's enable is 0, its outputs are 0 and its accumulator is cleared. After it is enabled again, the quota sequence restarts from k = 0.
- R10: Streams are independent. One stream's governor word, ready and enable do not affect another stream's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | NS | Per-stream enable; 0 clears that stream's state |
| gov_word | input | NS*32 | Governor words, stream i in bits [32*i +: 32] |
| pkt_start | input | 1 | One-cycle strobe at each packet boundary |
| sym_ready | input | NS | Upstream has a symbol for stream i |
| sym_release | output | NS | Release one symbol of stream i this cycle |
| stuff | output | NS | Stream i has spent its quota; send stuffing |

## Verification
Release and stuff are combinational from the registered packet state and the current `sym_ready` and `enable`. They are therefore due in the same cycle as the inputs that cause them. A quota taken at a `pkt_start` edge governs outputs from the next cycle on. A disable silences the outputs at once and clears the state at the next edge. The bench drives every input at the falling edge and samples 1 ns later, before the next rising edge. Its reference model advances only after that sample, so each compare sees exactly the state of the registers at that edge. Per-packet release totals are compared against the closed-form quota of R4 once the packet window ends.

// File: rtl/rgp_pkg.sv
package rgp_pkg;
   localparam int GOV_W   = 32;  // governor word width per stream
   localparam int INT_LSB = 16;  // lowest bit of the integer field
endpackage

// File: rtl/rgp_frac_acc.sv
// Fractional accumulator: turns x_int + y_frac/2^FRAC_W into an integer quota per packet.
module rgp_frac_acc #(
   parameter int FRAC_W = 8,
   parameter int INT_W  = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic [INT_W-1:0] x_int,
   input  logic [FRAC_W-1:0] y_frac,
   output logic [INT_W:0]   quota
);
   logic [FRAC_W-1:0] acc_q;
   logic [FRAC_W:0]   sum;

   assign sum = {1'b0, acc_q} + {1'b0, y_frac};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         quota <= '0;
      end else if (clr) begin
         acc_q <= '0;
         quota <= '0;
      end else if (step) begin
         acc_q <= sum[FRAC_W-1:0];
         quota <= {1'b0, x_int} + {{INT_W{1'b0}}, sum[FRAC_W]};
      end
   end
endmodule

// File: rtl/rgp_budget.sv
// Per-packet symbol budget: counts releases against the quota, flags stuffing.
module rgp_budget #(
   parameter int INT_W = 10
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           start,
   input  logic [INT_W:0] quota,
   input  logic           ready,
   output logic           release_o,
   output logic           stuff_o
);
   logic [INT_W:0] used_q;
   logic           open_q;
   logic           room;
   logic           live;

   assign room      = used_q < quota;
   assign live      = open_q && !start && !clr;
   assign release_o = live && ready && room;
   assign stuff_o   = live && !room;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         used_q <= '0;
         open_q <= 1'b0;
      end else if (clr) begin
         used_q <= '0;
         open_q <= 1'b0;
      end else if (start) begin
         used_q <= '0;
         open_q <= 1'b1;
      end else if (release_o) begin
         used_q <= used_q + 1'b1;
      end
   end
endmodule

// File: rtl/rgp_pacer.sv
// Multi-stream fractional rate governor pacer.
module rgp_pacer
   import rgp_pkg::*;
#(
   parameter int NS     = 2,
   parameter int FRAC_W = 8,
   parameter int INT_W  = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NS-1:0]      enable,
   input  logic [NS*GOV_W-1:0] gov_word,
   input  logic               pkt_start,
   input  logic [NS-1:0]      sym_ready,
   output logic [NS-1:0]      sym_release,
   output logic [NS-1:0]      stuff
);
   localparam int INT_MSB = INT_LSB + INT_W - 1;

   if (NS < 1) begin : g_bad_ns
      $error("rgp_pacer: NS must be at least 1");
   end
   if (FRAC_W < 1 || FRAC_W > INT_LSB) begin : g_bad_frac
      $error("rgp_pacer: FRAC_W must lie in 1..INT_LSB");
   end
   if (INT_W < 1 || INT_MSB >= GOV_W) begin : g_bad_int
      $error("rgp_pacer: integer field does not fit the governor word");
   end

   for (genvar s = 0; s < NS; s++) begin : g_stream
      logic [INT_W-1:0]  x_fld;
      logic [FRAC_W-1:0] y_fld;
      logic [INT_W:0]    quota;
      logic              clr;
      logic              step;

      assign x_fld = gov_word[s*GOV_W + INT_LSB +: INT_W];
      assign y_fld = gov_word[s*GOV_W +: FRAC_W];
      assign clr   = !enable[s];
      assign step  = pkt_start && enable[s];

      rgp_frac_acc #(.FRAC_W(FRAC_W), .INT_W(INT_W)) i_acc (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (clr),
         .step   (step),
         .x_int  (x_fld),
         .y_frac (y_fld),
         .quota  (quota)
      );

      rgp_budget #(.INT_W(INT_W)) i_budget (
         .clk       (clk),
         .rst_n     (rst_n),
         .clr       (clr),
         .start     (pkt_start),
         .quota     (quota),
         .ready     (sym_ready[s]),
         .release_o (sym_release[s]),
         .stuff_o   (stuff[s])
      );
   end
endmodule

// File: rtl/rgp_pacer_chk.sv
// Property checker attached to every rgp_pacer instance.
module rgp_pacer_chk #(
   parameter int NS = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic [NS-1:0] enable,
   input logic          pkt_start,
   input logic [NS-1:0] sym_ready,
   input logic [NS-1:0] sym_release,
   input logic [NS-1:0] stuff
);
   always_comb begin
      if (!rst_n) begin
         p_reset_quiet_r1: assert (sym_release == '0 && stuff == '0);
      end
   end

   for (genvar s = 0; s < NS; s++) begin : g_prop
      p_release_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
         sym_release[s] |-> (sym_ready[s] && enable[s]));

      p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !(sym_release[s] && stuff[s]));

      p_stuff_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (stuff[s] && !pkt_start) |=> (pkt_start || !enable[s] || stuff[s]));

      p_boundary_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
         pkt_start |-> (!sym_release[s] && !stuff[s]));

      p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !enable[s] |-> (!sym_release[s] && !stuff[s]));
   end
endmodule

bind rgp_pacer rgp_pacer_chk #(.NS(NS)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .enable      (enable),
   .pkt_start   (pkt_start),
   .sym_ready   (sym_ready),
   .sym_release (sym_release),
   .stuff       (stuff)
);

// File: tb/test_rgp_pacer.sv
`timescale 1ns/1ps
module test_rgp_pacer;
   localparam int NS = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] en = '0;
   logic [63:0]   gov = '0;
   logic          pk = 1'b0;
   logic [NS-1:0] rdy = '0;
   logic [NS-1:0] rel;
   logic [NS-1:0] stf;

   int n_chk = 0;
   int n_bad = 0;
   int m_acc [NS];
   int m_quota [NS];
   int m_used [NS];
   bit m_open [NS];
   int rel_cnt [NS];
   int total;

   always #4 clk = ~clk;

   rgp_pacer i_rgp_pacer (
      .clk(clk), .rst_n(rst_n), .enable(en), .gov_word(gov),
      .pkt_start(pk), .sym_ready(rdy), .sym_release(rel), .stuff(stf)
   );

   initial begin
      #1_500_000;
      n_bad++;
      $display("FAIL watchdog: run hung, actual running expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
      end
   endtask

   function automatic int exp_q(input int x, input int y, input int k);
      return x + (((k + 1) * y) >> 8) - ((k * y) >> 8);
   endfunction

   function automatic logic [31:0] mk(input int x, input int y);
      return (32'(x) << 16) | 32'(y & 255);
   endfunction

   // inputs were set at a falling edge; compare, advance model, go to next falling edge
   task automatic tick(input string tag);
      #1;
      for (int i = 0; i < NS; i++) begin
         int x = int'(gov[i*32+16 +: 10]);
         int y = int'(gov[i*32 +: 8]);
         bit live = en[i] && m_open[i] && !pk;
         bit e_rel = live && rdy[i] && (m_used[i] < m_quota[i]);
         bit e_stf = live && !(m_used[i] < m_quota[i]);
         chk({tag, " R5 release"}, int'(rel[i]), int'(e_rel));
         chk({tag, " R6 stuff"}, int'(stf[i]), int'(e_stf));
         if (pk) rel_cnt[i] = 0;
         else if (rel[i]) rel_cnt[i]++;
         if (!en[i]) begin
            m_acc[i] = 0; m_quota[i] = 0; m_used[i] = 0; m_open[i] = 0;
         end else if (pk) begin
            int s = m_acc[i] + y;
            m_acc[i] = s & 255; m_quota[i] = x + (s >> 8); m_used[i] = 0; m_open[i] = 1;
         end else if (e_rel) begin
            m_used[i]++;
         end
      end
      @(negedge clk);
   endtask

   task automatic run_pkt(input int len, input string tag);
      pk = 1'b1;
      tick(tag);
      pk = 1'b0;
      for (int c = 1; c < len; c++) tick(tag);
   endtask

   task automatic restart(input string tag);
      en = '0;
      tick(tag);
      en = '1;
   endtask

   initial begin
      for (int i = 0; i < NS; i++) begin
         m_acc[i] = 0; m_quota[i] = 0; m_used[i] = 0; m_open[i] = 0; rel_cnt[i] = 0;
      end
      void'($urandom(32'h5EED_0042));
      en = '1; rdy = '1; gov = {mk(4, 0), mk(4, 0)};
      @(negedge clk); #1;
      chk("R1 reset release", int'(rel), 0);
      chk("R1 reset stuff", int'(stf), 0);
      @(negedge clk);
      rst_n = 1'b1;
      en = '0;
      @(negedge clk);

      // R7: enabled but no boundary yet
      en = '1; gov = {mk(5, 0), mk(3, 0)};
      for (int c = 0; c < 3; c++) begin
         tick("R7 pre-boundary");
         chk("R7 no output before boundary", int'(rel | stf), 0);
      end

      // R3: zero fraction gives constant quota
      for (int p = 0; p < 5; p++) begin
         run_pkt(7, "R3");
         chk("R3 stream0 count", rel_cnt[0], 3);
         chk("R10 stream1 count", rel_cnt[1], 5);
      end

      // R4: x=3 y=64 -> 3,3,3,4 pattern
      restart("R9");
      gov = {mk(5, 0), mk(3, 64)};
      for (int k = 0; k < 8; k++) begin
         run_pkt(6, "R4");
         chk("R4 short pattern", rel_cnt[0], exp_q(3, 64, k));
         chk("R10 neighbour unaffected", rel_cnt[1], 5);
      end

      // R4: total over 256 packets
      restart("R9");
      gov = {mk(1, 200), mk(2, 8'h5B)};
      total = 0;
      for (int k = 0; k < 256; k++) begin
         run_pkt(5, "R4");
         chk("R4 per-packet", rel_cnt[0], exp_q(2, 8'h5B, k));
         total += rel_cnt[0];
      end
      chk("R4 total over 256 packets", total, 256 * 2 + 8'h5B);

      // R2: junk outside the fields has no effect
      restart("R9");
      gov[31:0] = 32'hFC00_FF00 | mk(2, 128);
      for (int k = 0; k < 4; k++) begin
         run_pkt(6, "R2");
         chk("R2 field layout", rel_cnt[0], exp_q(2, 128, k));
      end

      // R8: mid-packet change applies at next boundary
      restart("R9");
      gov[31:0] = mk(2, 0);
      pk = 1'b1; tick("R8"); pk = 1'b0;
      tick("R8");
      gov[31:0] = mk(4, 0);
      for (int c = 0; c < 5; c++) tick("R8");
      chk("R8 old quota kept", rel_cnt[0], 2);
      run_pkt(7, "R8");
      chk("R8 new quota used", rel_cnt[0], 4);

      // R9: disable clears the accumulator
      restart("R9");
      gov[31:0] = mk(1, 128);
      run_pkt(4, "R9");
      chk("R9 first packet", rel_cnt[0], 1);
      restart("R9");
      run_pkt(4, "R9");
      chk("R9 restart from k=0", rel_cnt[0], 1);
      run_pkt(4, "R9");
      chk("R9 second packet carries", rel_cnt[0], 2);

      // R6: stuff with ready low after quota spent
      gov[31:0] = mk(1, 0);
      run_pkt(2, "R6");
      rdy[0] = 1'b0;
      tick("R6");
      chk("R6 stuff with ready low", int'(stf[0]), 1);
      rdy = '1;

      // constrained random mix, model checks every cycle (R5 R6 R10)
      for (int c = 0; c < 3000; c++) begin
         pk  = ($urandom_range(0, 5) == 0);
         rdy = NS'($urandom);
         if ($urandom_range(0, 60) == 0) en[$urandom_range(0, NS - 1)] ^= 1'b1;
         if ($urandom_range(0, 40) == 0)
            gov[$urandom_range(0, NS - 1)*32 +: 32] = $urandom;
         tick("random");
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule